// File: doc/BRIEF.md
# Shared Video Memory Bus Arbiter

This block lets one RAM array serve both an 8-bit processor and a display refresh path. It runs from the 4 MHz master clock. A two-bit phase register cuts every 1 us slot into four phases. Phase 0 belongs to the processor. Phases 1 and 2 fetch two adjacent display bytes for the pixel shifter. Phase 3 is spare and carries the display-timing clock enable. The processor's active-low wait line is held low in every phase but phase 0. As a result, each processor bus cycle finishes at the same point of a slot.

The block multiplexes the RAM address between the processor and the display address. A display fetch builds its address from the word address supplied by the display timing logic, with the lowest address bit taken from the phase. Processor read data is caught in a holding register, because RAM ownership goes back to the display path before the processor takes the data. A processor memory write is held off for one extra full slot. I/O cycles are aligned the same way but never touch the RAM. The block also produces a 1 MHz address-bit square wave, a 1 MHz sound-device clock, and a once-per-slot clock enable for the display timing logic.

Two state machines do the work. The phase machine runs through the states PH_CPU, PH_FETCH_LO, PH_FETCH_HI and PH_SPARE, then returns to PH_CPU. The access machine has two states:
- ACC_IDLE moves to ACC_DEFER in PH_CPU when a memory write is pending.
- ACC_DEFER returns to ACC_IDLE at the next PH_CPU, where the write is granted.

Top module: `vram_arbiter`

## Requirements
- R1: After reset the phase is 0. It then advances by one every master clock and wraps from 3 back to 0.
- R2: `cpu_wait_n` is low in phases 1, 2 and 3. In phase 0 it is high, except for the first phase 0 seen by a pending memory write.
- R3: A memory read, I/O read or I/O write completes (request high and `cpu_wait_n` high at a clock edge) at the first phase 0 on or after the request. A memory write completes at the second phase 0, four cycles later than a read raised in the same phase.
- R4: `ram_addr` equals `cpu_addr` in phase 0. In phase 1 it is `{disp_addr, 1'b0}`, and in phases 2 and 3 it is `{disp_addr, 1'b1}`.
- R5: `vid_load` is high exactly in phases 2 and 3. In phase 2, `vid_byte` holds the RAM byte at `{disp_addr, 1'b0}` read in phase 1. In phase 3 it holds the byte at `{disp_addr, 1'b1}` read in phase 2.
- R6: `cpu_rdata` captures `ram_rdata` at the edge where a memory read completes. It keeps that value through all later phases until the next memory read completes. I/O reads leave it unchanged.
- R7: `ram_we` is high only in the phase-0 cycle where a memory write completes. I/O writes and display phases never assert it.
- R8: `vid_a0` is 0 in phases 0 and 1 and 1 in phases 2 and 3. `snd_clk` is 1 in phases 1 and 2. `crtc_ce` is 1 only in phase 3.
- R9: While reset is asserted, the phase is 0, `cpu_rdata` and `vid_byte` are 0, `vid_load` is 0, and the access machine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor bus cycle in progress, held until done |
| cpu_we | input | 1 | Cycle is a write |
| cpu_io | input | 1 | Cycle is an I/O cycle, not a memory cycle |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_wait_n | output | 1 | Active-low wait to the processor |
| cpu_rdata | output | DATA_W | Held processor read data |
| disp_addr | input | ADDR_W-1 | Display word address from the timing logic |
| ram_addr | output | ADDR_W | Multiplexed RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_rdata | input | DATA_W | RAM read data (combinational RAM) |
| vid_byte | output | DATA_W | Display byte for the pixel shifter |
| vid_load | output | 1 | Load strobe for `vid_byte` |
| crtc_ce | output | 1 | Once-per-slot clock enable for display timing |
| snd_clk | output | 1 | 1 MHz sound-device clock |
| vid_a0 | output | 1 | Phase-derived low address bit, 1 MHz square wave |

## Verification
Every processor cycle kind (memory read, memory write, I/O read, I/O write) is launched in each of the four phases. The measured wait count therefore separates a correct per-phase alignment from an off-by-one phase decode, and separates the extra write slot from a missing or doubled one. Each write is followed by a read-back. That read-back tells a real RAM update apart from an I/O write that leaks into memory. A long idle stretch after a read shows whether the held data survives the display fetches. Several display word addresses, including all-zeros and all-ones, check that the two fetched bytes come from the even and odd address and in that order.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

    typedef enum logic [1:0] {
        PH_CPU      = 2'd0,
        PH_FETCH_LO = 2'd1,
        PH_FETCH_HI = 2'd2,
        PH_SPARE    = 2'd3
    } phase_e;

    typedef enum logic {
        ACC_IDLE  = 1'b0,
        ACC_DEFER = 1'b1
    } acc_e;

endpackage

// File: rtl/vram_phase_gen.sv
module vram_phase_gen
    import vram_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase,
    output logic   vid_a0,
    output logic   snd_clk,
    output logic   crtc_ce
);

    phase_e ph_q;
    phase_e ph_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_CPU;
        else        ph_q <= ph_d;
    end

    // transitions: fixed ring
    always_comb begin
        unique case (ph_q)
            PH_CPU:      ph_d = PH_FETCH_LO;
            PH_FETCH_LO: ph_d = PH_FETCH_HI;
            PH_FETCH_HI: ph_d = PH_SPARE;
            PH_SPARE:    ph_d = PH_CPU;
            default:     ph_d = PH_CPU;
        endcase
    end

    // outputs decoded from the state register
    always_comb begin
        vid_a0  = 1'b0;
        snd_clk = 1'b0;
        crtc_ce = 1'b0;
        unique case (ph_q)
            PH_CPU: begin
            end
            PH_FETCH_LO: begin
                snd_clk = 1'b1;
            end
            PH_FETCH_HI: begin
                vid_a0  = 1'b1;
                snd_clk = 1'b1;
            end
            PH_SPARE: begin
                vid_a0  = 1'b1;
                crtc_ce = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign phase = ph_q;

endmodule

// File: rtl/vram_cpu_port.sv
module vram_cpu_port
    import vram_arb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_io,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              cpu_wait_n,
    output logic              ram_we,
    output logic [DATA_W-1:0] cpu_rdata,
    output acc_e              acc_state
);

    acc_e st_q;
    acc_e st_d;
    logic in_cpu;
    logic mem_wr;
    logic grant;
    logic rd_take;

    assign in_cpu = (phase == PH_CPU);
    assign mem_wr = cpu_req && cpu_we && !cpu_io;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ACC_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        unique case (st_q)
            ACC_IDLE:  st_d = (in_cpu && mem_wr) ? ACC_DEFER : ACC_IDLE;
            ACC_DEFER: st_d = in_cpu ? ACC_IDLE : ACC_DEFER;
            default:   st_d = ACC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_wait_n = 1'b0;
        unique case (st_q)
            ACC_IDLE:  cpu_wait_n = in_cpu && !mem_wr;
            ACC_DEFER: cpu_wait_n = in_cpu;
            default:   cpu_wait_n = 1'b0;
        endcase
        grant   = cpu_req && cpu_wait_n;
        ram_we  = grant && mem_wr;
        rd_take = grant && !cpu_we && !cpu_io;
    end

    // read holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cpu_rdata <= '0;
        else if (rd_take) cpu_rdata <= ram_rdata;
    end

    assign acc_state = st_q;

endmodule

// File: rtl/vram_vid_fetch.sv
module vram_vid_fetch
    import vram_arb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] vid_byte,
    output logic              vid_load
);

    logic fetch_now;

    always_comb begin
        unique case (phase)
            PH_FETCH_LO, PH_FETCH_HI: fetch_now = 1'b1;
            PH_CPU, PH_SPARE:         fetch_now = 1'b0;
            default:                  fetch_now = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vid_byte <= '0;
            vid_load <= 1'b0;
        end else begin
            vid_load <= fetch_now;
            if (fetch_now) vid_byte <= ram_rdata;
        end
    end

endmodule

// File: rtl/vram_arbiter.sv
module vram_arbiter
    import vram_arb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_io,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_wait_n,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [ADDR_W-2:0] disp_addr,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] vid_byte,
    output logic              vid_load,
    output logic              crtc_ce,
    output logic              snd_clk,
    output logic              vid_a0
);

    phase_e phase;
    acc_e   acc_state;

    vram_phase_gen u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .vid_a0  (vid_a0),
        .snd_clk (snd_clk),
        .crtc_ce (crtc_ce)
    );

    vram_cpu_port #(.DATA_W(DATA_W)) u_cpu (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_io     (cpu_io),
        .ram_rdata  (ram_rdata),
        .cpu_wait_n (cpu_wait_n),
        .ram_we     (ram_we),
        .cpu_rdata  (cpu_rdata),
        .acc_state  (acc_state)
    );

    vram_vid_fetch #(.DATA_W(DATA_W)) u_vid (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .ram_rdata (ram_rdata),
        .vid_byte  (vid_byte),
        .vid_load  (vid_load)
    );

    // address source: processor only in its own phase
    always_comb begin
        if (phase == PH_CPU) ram_addr = cpu_addr;
        else                 ram_addr = {disp_addr, vid_a0};
    end

    assign ram_wdata = cpu_wdata;

endmodule

// File: rtl/vram_arbiter_chk.sv
module vram_arbiter_chk
    import vram_arb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input phase_e            phase,
    input acc_e              acc_state,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_io,
    input logic              cpu_wait_n,
    input logic              ram_we,
    input logic              vid_load,
    input logic              crtc_ce,
    input logic [DATA_W-1:0] cpu_rdata
);

    p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> phase == phase_e'(2'($past(phase)) + 2'd1));

    p_wait_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_CPU) |-> !cpu_wait_n);

    p_write_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CPU && acc_state == ACC_IDLE && cpu_req && cpu_we && !cpu_io)
        |=> (acc_state == ACC_DEFER && !ram_we));

    p_vid_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vid_load |-> (phase == PH_FETCH_HI || phase == PH_SPARE));

    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_req && cpu_wait_n && !cpu_we && !cpu_io) |=> $stable(cpu_rdata));

    p_we_cpu_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (phase == PH_CPU && acc_state == ACC_DEFER));

    p_crtc_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        crtc_ce |-> (phase == PH_SPARE));

endmodule

bind vram_arbiter vram_arbiter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .acc_state  (acc_state),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_io     (cpu_io),
    .cpu_wait_n (cpu_wait_n),
    .ram_we     (ram_we),
    .vid_load   (vid_load),
    .crtc_ce    (crtc_ce),
    .cpu_rdata  (cpu_rdata)
);

// File: tb/sim_vram_arbiter.sv
module sim_vram_arbiter;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int NMEM = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic          cpu_io = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_wait_n;
    logic [DW-1:0] cpu_rdata;
    logic [AW-2:0] disp_addr = '0;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic          ram_we;
    logic [DW-1:0] ram_rdata;
    logic [DW-1:0] vid_byte;
    logic          vid_load;
    logic          crtc_ce;
    logic          snd_clk;
    logic          vid_a0;

    vram_arbiter #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_io(cpu_io), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wait_n(cpu_wait_n), .cpu_rdata(cpu_rdata), .disp_addr(disp_addr),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .ram_rdata(ram_rdata), .vid_byte(vid_byte), .vid_load(vid_load),
        .crtc_ce(crtc_ce), .snd_clk(snd_clk), .vid_a0(vid_a0)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit mon_en = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference phase, from R1
    logic [1:0] bph;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) bph <= 2'd0;
        else        bph <= bph + 2'd1;
    end

    // RAM model and reference contents
    logic [DW-1:0] mem [NMEM];
    logic [DW-1:0] ref_mem [NMEM];
    assign ram_rdata = mem[ram_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NMEM; i++) mem[i] <= DW'(i * 7 + 3);
        end else if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
        end
    end

    // per-cycle monitor
    logic [DW-1:0] exp_lo, exp_hi;
    always @(negedge clk) begin
        #2;
        if (rst_n && mon_en) begin
            check({vid_a0, snd_clk, crtc_ce} ==
                  {bph >= 2'd2, bph == 2'd1 || bph == 2'd2, bph == 2'd3},
                  "R8 derived clocks", int'({vid_a0, snd_clk, crtc_ce}), int'(bph));
            check(vid_load == (bph == 2'd2 || bph == 2'd3), "R5 load strobe",
                  int'(vid_load), int'(bph == 2'd2 || bph == 2'd3));
            if (bph == 2'd0) begin
                check(ram_addr == cpu_addr, "R4 cpu address", int'(ram_addr), int'(cpu_addr));
            end else begin
                check(!cpu_wait_n, "R2 wait low", int'(cpu_wait_n), 0);
                check(!ram_we, "R7 no write in video phase", int'(ram_we), 0);
                check(ram_addr == {disp_addr, bph >= 2'd2}, "R4 video address",
                      int'(ram_addr), int'({disp_addr, bph >= 2'd2}));
            end
            if (bph == 2'd1) exp_lo = mem[{disp_addr, 1'b0}];
            if (bph == 2'd2) begin
                exp_hi = mem[{disp_addr, 1'b1}];
                check(vid_byte == exp_lo, "R5 even byte", int'(vid_byte), int'(exp_lo));
            end
            if (bph == 2'd3)
                check(vid_byte == exp_hi, "R5 odd byte", int'(vid_byte), int'(exp_hi));
        end
    end

    // kind: 0 mem read, 1 mem write, 2 io read, 3 io write
    task automatic access(input int p, input int kind, input logic [AW-1:0] a,
                          input logic [DW-1:0] d);
        int lat;
        int exp_lat;
        logic [DW-1:0] prev;
        while (bph != 2'(p)) @(negedge clk);
        cpu_req   = 1'b1;
        cpu_we    = (kind == 1 || kind == 3);
        cpu_io    = (kind >= 2);
        cpu_addr  = a;
        cpu_wdata = d;
        exp_lat = ((4 - p) % 4) + ((kind == 1) ? 4 : 0);
        lat = 0;
        #1;
        while (!cpu_wait_n && lat < 20) begin
            @(negedge clk);
            #1;
            lat++;
        end
        check(lat == exp_lat, "R3 completion delay", lat, exp_lat);
        check(bph == 2'd0, "R3 completion phase", int'(bph), 0);
        check(ram_we == (kind == 1), "R7 write strobe", int'(ram_we), int'(kind == 1));
        prev = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
        cpu_we  = 1'b0;
        cpu_io  = 1'b0;
        #1;
        if (kind == 0)
            check(cpu_rdata == ref_mem[a], "R6 read capture", int'(cpu_rdata), int'(ref_mem[a]));
        else if (kind == 2)
            check(cpu_rdata == prev, "R6 io read keeps latch", int'(cpu_rdata), int'(prev));
        else if (kind == 1)
            ref_mem[a] = d;
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R3 watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        for (int i = 0; i < NMEM; i++) ref_mem[i] = DW'(i * 7 + 3);
        repeat (5) @(posedge clk);
        @(negedge clk);
        #1;
        // R9 reset state
        check(cpu_rdata == '0, "R9 rdata", int'(cpu_rdata), 0);
        check(vid_byte == '0 && !vid_load, "R9 video", int'({vid_load, vid_byte}), 0);
        check(cpu_wait_n && !crtc_ce && !vid_a0, "R9 phase 0 outputs",
              int'({cpu_wait_n, crtc_ce, vid_a0}), 4);
        rst_n = 1'b1;
        mon_en = 1'b1;
        #1;

        // R1 phase progression seen through vid_a0/snd_clk/crtc_ce (monitor), R3 sweep
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 4; k++) begin
                logic [AW-1:0] a;
                a = AW'(p * 37 + k * 11 + 5);
                access(p, k, a, DW'(p * 16 + k + 8'h80));
                if (k == 1 || k == 3) access((p + 1) % 4, 0, a, '0);
            end
        end

        // R6 hold across many display fetches
        access(2, 0, AW'(8'h41), '0);
        held = cpu_rdata;
        repeat (9) @(negedge clk);
        #1;
        check(cpu_rdata == held, "R6 hold", int'(cpu_rdata), int'(held));

        // R5 display addresses
        for (int v = 0; v < 6; v++) begin
            while (bph != 2'd0) @(negedge clk);
            case (v)
                0: disp_addr = '0;
                1: disp_addr = '1;
                2: disp_addr = 7'h15;
                3: disp_addr = 7'h2a;
                4: disp_addr = 7'h40;
                default: disp_addr = 7'h3f;
            endcase
            repeat (8) @(negedge clk);
            #1;
        end

        // mixed random traffic
        for (int n = 0; n < 150; n++) begin
            int p, k;
            p = int'($urandom % 4);
            k = int'($urandom % 4);
            access(p, k, AW'($urandom), DW'($urandom));
            if (n % 10 == 0) access(0, 0, AW'($urandom), '0);
        end

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule